// File: doc/BRIEF.md
# Settable BCD Perpetual Calendar Counter

This block holds a calendar date as eight BCD digits: four for the year, two for the month and two for the day. Each single-cycle day-tick pulse advances the date by one day. Month lengths follow the Gregorian rules, and February's length depends on a leap-year test made directly on the BCD year digits. A leap-year flag is output so a display can show it. On a board the tick is usually one pulse per second, so the date visibly runs through the years.

Three pre-debounced, single-cycle key pulses edit the date in place:

- **Mode key:** toggles setting mode.
- **Select key:** moves a cursor across the eight digits.
- **Increment key:** adds one to the digit under the cursor. The digit wraps within the range legal for its position.

While setting mode is active, day counting stops. On leaving setting mode, an out-of-range month or day is pulled back to a legal value. The digits, the leap flag, the mode flag and the cursor are all registered outputs. An external display driver reads them.

Top module: `cal_core`

## Requirements
- R1: After reset (rst_n low) the date reads year 0001, month 01, day 01, with setting mode off and the cursor at 0.
- R2: With setting mode off and no mode key, a day_tick on a day below the month's length adds one to the BCD day, carrying from the ones digit into the tens digit, on the next clock.
- R3: Months 04, 06, 09 and 11 last 30 days, and months 01, 03, 05, 07, 08, 10 and 12 last 31 days. A tick on a month's last day gives day 01 of the next month, and the month carries in BCD (09 to 10).
- R4: February lasts 29 days when the year is a leap year and 28 days otherwise. A year is a leap year when it divides by 4 and not by 100, or when it divides by 400. leap_year shows this test for the current year, including year 0000.
- R5: A tick on day 31 of month 12 gives month 01, day 01, and adds one to the year with a BCD carry through all four digits. Year 9999 becomes 0001.
- R6: A mode key pulse toggles set_mode. Entering setting mode moves the cursor to position 0.
- R7: While set_mode is high, day_tick has no effect on the date.
- R8: In setting mode, a select pulse advances the cursor by one, and position 7 wraps to 0. The positions are 0 = year thousands, 1 = year hundreds, 2 = year tens, 3 = year ones, 4 = month tens, 5 = month ones, 6 = day tens and 7 = day ones.
- R9: In setting mode, an increment pulse adds one to the digit at the cursor. Month tens wraps 1 to 0, day tens wraps 3 to 0, and every other digit wraps 9 to 0. If select and increment arrive together, the digit at the old cursor is edited and the cursor then moves.
- R10: With setting mode off, select and increment pulses change neither the date nor the cursor.
- R11: On leaving setting mode, month 00 becomes 01 and a month above 12 becomes 12. After that, day 00 becomes 01, and a day above the resulting month's length (for the current year) becomes that length.
- R12: A mode key pulse takes precedence. In the same cycle, day_tick, select and increment are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| day_tick | input | 1 | Single-cycle pulse, advance one day |
| key_mode | input | 1 | Debounced pulse, toggle setting mode |
| key_sel | input | 1 | Debounced pulse, move cursor |
| key_inc | input | 1 | Debounced pulse, increment digit at cursor |
| year_th | output | 4 | Year thousands digit (BCD) |
| year_hu | output | 4 | Year hundreds digit (BCD) |
| year_te | output | 4 | Year tens digit (BCD) |
| year_on | output | 4 | Year ones digit (BCD) |
| mon_te | output | 4 | Month tens digit (BCD) |
| mon_on | output | 4 | Month ones digit (BCD) |
| day_te | output | 4 | Day tens digit (BCD) |
| day_on | output | 4 | Day ones digit (BCD) |
| leap_year | output | 1 | Current year is a leap year |
| set_mode | output | 1 | Setting mode active |
| cursor | output | 3 | Digit position under edit |

## Verification
The main function is driven in several ways:

- **Long tick run:** about four years of ticks from reset. This separates a one-day step from month and year rollover, and a common February from the February of year 0004.
- **Edited-in dates:** 1900, 2000 and 2100 February dates separate the century exceptions from the plain divide-by-4 rule. A 9999 year-end date exposes the four-digit BCD carry and the wrap to 0001.
- **Illegal dates at exit:** months 00 and 19 and days 00 and 39, left in place on exit, separate the month fix-up from the day clamp and show which month length the clamp uses.
- **Key combinations:** keys pressed outside setting mode, and keys pressed together with the mode key, separate ignored inputs from applied ones.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int unsigned DIGIT_W    = 4;
    localparam int unsigned YEAR_DIGS  = 4;
    localparam int unsigned DATE_DIGS  = 8;
    localparam int unsigned CUR_W      = $clog2(DATE_DIGS);
    localparam int unsigned BIN_W      = 7;

    typedef struct packed {
        logic [DIGIT_W-1:0] yth;
        logic [DIGIT_W-1:0] yhu;
        logic [DIGIT_W-1:0] yte;
        logic [DIGIT_W-1:0] yon;
        logic [DIGIT_W-1:0] mte;
        logic [DIGIT_W-1:0] mon;
        logic [DIGIT_W-1:0] dte;
        logic [DIGIT_W-1:0] don;
    } cal_date_t;

    typedef struct packed {
        cal_date_t          date;
        logic               setting;
        logic [CUR_W-1:0]   cursor;
    } cal_state_t;

    // Largest legal value for the digit at a cursor position.
    function automatic logic [DIGIT_W-1:0] digit_max(input int unsigned pos);
        case (pos)
            4:       return DIGIT_W'(1);
            6:       return DIGIT_W'(3);
            default: return DIGIT_W'(9);
        endcase
    endfunction

    // Two BCD digits to a small binary value.
    function automatic logic [BIN_W-1:0] bcd2bin(input logic [DIGIT_W-1:0] t,
                                                 input logic [DIGIT_W-1:0] o);
        return BIN_W'(t) * BIN_W'(10) + BIN_W'(o);
    endfunction

endpackage

// File: rtl/cal_leap.sv
module cal_leap
    import cal_pkg::*;
(
    input  logic [DIGIT_W-1:0] yth,
    input  logic [DIGIT_W-1:0] yhu,
    input  logic [DIGIT_W-1:0] yte,
    input  logic [DIGIT_W-1:0] yon,
    output logic               leap
);
    // A two-digit BCD number divides by 4 when an even tens digit pairs
    // with ones 0/4/8, or an odd tens digit pairs with ones 2/6.
    function automatic logic pair_div4(input logic [DIGIT_W-1:0] t,
                                       input logic [DIGIT_W-1:0] o);
        if (t[0] == 1'b0)
            return (o == DIGIT_W'(0)) || (o == DIGIT_W'(4)) || (o == DIGIT_W'(8));
        else
            return (o == DIGIT_W'(2)) || (o == DIGIT_W'(6));
    endfunction

    logic low_zero;

    always_comb begin
        low_zero = (yte == '0) && (yon == '0);
        // Low pair zero: the year is a multiple of 100, so divisibility
        // by 400 reduces to the high pair dividing by 4.
        leap = low_zero ? pair_div4(yth, yhu) : pair_div4(yte, yon);
    end

endmodule

// File: rtl/cal_mlen.sv
module cal_mlen
    import cal_pkg::*;
(
    input  logic [DIGIT_W-1:0] mte,
    input  logic [DIGIT_W-1:0] mon,
    input  logic               leap,
    output logic [DIGIT_W-1:0] len_te,
    output logic [DIGIT_W-1:0] len_on
);
    always_comb begin
        len_te = DIGIT_W'(3);
        len_on = DIGIT_W'(1);
        case ({mte, mon})
            8'h02: begin
                len_te = DIGIT_W'(2);
                len_on = leap ? DIGIT_W'(9) : DIGIT_W'(8);
            end
            8'h04, 8'h06, 8'h09, 8'h11: begin
                len_te = DIGIT_W'(3);
                len_on = DIGIT_W'(0);
            end
            default: begin
                len_te = DIGIT_W'(3);
                len_on = DIGIT_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/cal_year_inc.sv
module cal_year_inc
    import cal_pkg::*;
#(
    parameter int unsigned NDIG = YEAR_DIGS
) (
    input  logic [DIGIT_W*NDIG-1:0] yr_i,   // ones digit in the low nibble
    output logic [DIGIT_W*NDIG-1:0] yr_o
);
    logic [NDIG:0]             carry;
    logic [DIGIT_W*NDIG-1:0]   raw;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [DIGIT_W-1:0] d;
        assign d = yr_i[DIGIT_W*i +: DIGIT_W];
        assign raw[DIGIT_W*i +: DIGIT_W] =
            !carry[i]              ? d :
            (d == DIGIT_W'(9))     ? '0 : d + DIGIT_W'(1);
        assign carry[i+1] = carry[i] && (d == DIGIT_W'(9));
    end

    // An all-nines year wraps to year one rather than zero.
    assign yr_o = carry[NDIG] ? {{(DIGIT_W*NDIG-1){1'b0}}, 1'b1} : raw;

endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               day_tick,
    input  logic               key_mode,
    input  logic               key_sel,
    input  logic               key_inc,
    output logic [3:0]         year_th,
    output logic [3:0]         year_hu,
    output logic [3:0]         year_te,
    output logic [3:0]         year_on,
    output logic [3:0]         mon_te,
    output logic [3:0]         mon_on,
    output logic [3:0]         day_te,
    output logic [3:0]         day_on,
    output logic               leap_year,
    output logic               set_mode,
    output logic [2:0]         cursor
);
    localparam int unsigned DATE_W = DIGIT_W * DATE_DIGS;

    cal_state_t st_d, st_q;

    // Helpers fed from the registered state.
    logic                    leap_now;
    logic [DIGIT_W-1:0]      len_te, len_on;
    logic [DIGIT_W-1:0]      fix_mte, fix_mon;
    logic [DIGIT_W-1:0]      fix_len_te, fix_len_on;
    logic [DIGIT_W*YEAR_DIGS-1:0] yr_next;

    cal_leap u_leap (
        .yth (st_q.date.yth), .yhu (st_q.date.yhu),
        .yte (st_q.date.yte), .yon (st_q.date.yon),
        .leap(leap_now)
    );

    cal_mlen u_len_now (
        .mte(st_q.date.mte), .mon(st_q.date.mon), .leap(leap_now),
        .len_te(len_te), .len_on(len_on)
    );

    cal_year_inc #(.NDIG(YEAR_DIGS)) u_yinc (
        .yr_i({st_q.date.yth, st_q.date.yhu, st_q.date.yte, st_q.date.yon}),
        .yr_o(yr_next)
    );

    // Month repair applied on leaving setting mode.
    logic [BIN_W-1:0] mon_bin;
    always_comb begin
        mon_bin = bcd2bin(st_q.date.mte, st_q.date.mon);
        fix_mte = st_q.date.mte;
        fix_mon = st_q.date.mon;
        if (mon_bin == '0) begin
            fix_mte = DIGIT_W'(0);
            fix_mon = DIGIT_W'(1);
        end else if (mon_bin > BIN_W'(12)) begin
            fix_mte = DIGIT_W'(1);
            fix_mon = DIGIT_W'(2);
        end
    end

    cal_mlen u_len_fix (
        .mte(fix_mte), .mon(fix_mon), .leap(leap_now),
        .len_te(fix_len_te), .len_on(fix_len_on)
    );

    // Next-state logic.
    logic [BIN_W-1:0]   day_bin, len_bin, fix_len_bin;
    logic [DATE_W-1:0]  dvec;

    always_comb begin
        st_d        = st_q;
        day_bin     = bcd2bin(st_q.date.dte, st_q.date.don);
        len_bin     = bcd2bin(len_te, len_on);
        fix_len_bin = bcd2bin(fix_len_te, fix_len_on);
        dvec        = st_q.date;

        if (key_mode) begin
            st_d.setting = !st_q.setting;
            if (!st_q.setting) begin
                st_d.cursor = '0;
            end else begin
                st_d.date.mte = fix_mte;
                st_d.date.mon = fix_mon;
                if (day_bin == '0) begin
                    st_d.date.dte = DIGIT_W'(0);
                    st_d.date.don = DIGIT_W'(1);
                end else if (day_bin > fix_len_bin) begin
                    st_d.date.dte = fix_len_te;
                    st_d.date.don = fix_len_on;
                end
            end
        end else if (st_q.setting) begin
            if (key_inc) begin
                for (int p = 0; p < DATE_DIGS; p++) begin
                    if (st_q.cursor == CUR_W'(p)) begin
                        dvec[DATE_W-1-DIGIT_W*p -: DIGIT_W] =
                            (dvec[DATE_W-1-DIGIT_W*p -: DIGIT_W] >= digit_max(p))
                                ? '0
                                : dvec[DATE_W-1-DIGIT_W*p -: DIGIT_W] + DIGIT_W'(1);
                    end
                end
                st_d.date = dvec;
            end
            if (key_sel) begin
                st_d.cursor = (st_q.cursor == CUR_W'(DATE_DIGS-1))
                              ? '0 : st_q.cursor + CUR_W'(1);
            end
        end else if (day_tick) begin
            if (day_bin < len_bin) begin
                if (st_q.date.don == DIGIT_W'(9)) begin
                    st_d.date.don = '0;
                    st_d.date.dte = st_q.date.dte + DIGIT_W'(1);
                end else begin
                    st_d.date.don = st_q.date.don + DIGIT_W'(1);
                end
            end else begin
                st_d.date.dte = DIGIT_W'(0);
                st_d.date.don = DIGIT_W'(1);
                if ({st_q.date.mte, st_q.date.mon} == 8'h12) begin
                    st_d.date.mte = DIGIT_W'(0);
                    st_d.date.mon = DIGIT_W'(1);
                    {st_d.date.yth, st_d.date.yhu,
                     st_d.date.yte, st_d.date.yon} = yr_next;
                end else if (st_q.date.mon == DIGIT_W'(9)) begin
                    st_d.date.mte = DIGIT_W'(1);
                    st_d.date.mon = DIGIT_W'(0);
                end else begin
                    st_d.date.mon = st_q.date.mon + DIGIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.date.yon <= DIGIT_W'(1);
            st_q.date.mon <= DIGIT_W'(1);
            st_q.date.don <= DIGIT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign year_th   = st_q.date.yth;
    assign year_hu   = st_q.date.yhu;
    assign year_te   = st_q.date.yte;
    assign year_on   = st_q.date.yon;
    assign mon_te    = st_q.date.mte;
    assign mon_on    = st_q.date.mon;
    assign day_te    = st_q.date.dte;
    assign day_on    = st_q.date.don;
    assign leap_year = leap_now;
    assign set_mode  = st_q.setting;
    assign cursor    = st_q.cursor;

    // Outside setting mode the date is always a legal one (R3, R11).
    p_legal_date_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.setting |-> (mon_bin >= BIN_W'(1)) && (mon_bin <= BIN_W'(12)) &&
                          (day_bin >= BIN_W'(1)) && (day_bin <= len_bin));

    p_tick_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.setting && !key_mode && day_tick) |=> !$stable(st_q.date));

    p_mode_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_mode |=> (st_q.setting != $past(st_q.setting)));

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.setting && !key_mode && !key_inc) |=> $stable(st_q.date));

    p_cursor_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.setting && !key_mode && key_sel &&
         st_q.cursor == CUR_W'(DATE_DIGS-1)) |=> (st_q.cursor == '0));

    p_keys_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.setting && !key_mode && !day_tick)
            |=> $stable(st_q.date) && $stable(st_q.cursor));

endmodule

// File: tb/cal_core_tb.sv
`timescale 1ns/1ps
module cal_core_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, day_tick, key_mode, key_sel, key_inc;
    logic [3:0] year_th, year_hu, year_te, year_on, mon_te, mon_on, day_te, day_on;
    logic leap_year, set_mode;
    logic [2:0] cursor;

    cal_core u_dut (
        .clk(clk), .rst_n(rst_n), .day_tick(day_tick), .key_mode(key_mode),
        .key_sel(key_sel), .key_inc(key_inc),
        .year_th(year_th), .year_hu(year_hu), .year_te(year_te), .year_on(year_on),
        .mon_te(mon_te), .mon_on(mon_on), .day_te(day_te), .day_on(day_on),
        .leap_year(leap_year), .set_mode(set_mode), .cursor(cursor)
    );

    typedef struct {
        logic [36:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    int dg[8];
    bit mset;
    int mcur;
    int lim[8] = '{10, 10, 10, 10, 2, 10, 4, 10};

    function automatic int yr();  return dg[0]*1000 + dg[1]*100 + dg[2]*10 + dg[3]; endfunction
    function automatic int mo();  return dg[4]*10 + dg[5]; endfunction
    function automatic int dy();  return dg[6]*10 + dg[7]; endfunction
    function automatic bit is_leap(int y);
        return (y % 400 == 0) || ((y % 4 == 0) && (y % 100 != 0));
    endfunction
    function automatic int mlen(int y, int m);
        if (m == 2) return is_leap(y) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction
    function automatic void put(int y, int m, int d);
        dg[0] = y / 1000; dg[1] = (y / 100) % 10; dg[2] = (y / 10) % 10; dg[3] = y % 10;
        dg[4] = m / 10;   dg[5] = m % 10;
        dg[6] = d / 10;   dg[7] = d % 10;
    endfunction
    function automatic logic [36:0] pack();
        logic [36:0] r;
        for (int p = 0; p < 8; p++) r[36-4*p -: 4] = 4'(dg[p]);
        r[4]   = is_leap(yr());
        r[3]   = mset;
        r[2:0] = 3'(mcur);
        return r;
    endfunction

    function automatic logic [36:0] actual();
        return {year_th, year_hu, year_te, year_on, mon_te, mon_on, day_te, day_on,
                leap_year, set_mode, cursor};
    endfunction

    task automatic check(string tag, logic [36:0] act, logic [36:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one stimulus cycle, model update, expected item queued.
    task automatic step(bit t, bit md, bit sl, bit inc);
        string tag;
        int y, m, d;
        @(negedge clk);
        day_tick = t; key_mode = md; key_sel = sl; key_inc = inc;
        if (md) begin
            if (!mset) begin
                mset = 1; mcur = 0; tag = "R6";
            end else begin
                mset = 0; tag = "R11";
                y = yr(); m = mo(); d = dy();
                if (m == 0) m = 1;
                if (m > 12) m = 12;
                if (d == 0) d = 1;
                if (d > mlen(y, m)) d = mlen(y, m);
                put(y, m, d);
            end
            if (t || sl || inc) tag = "R12";
        end else if (mset) begin
            tag = "R7";
            if (inc) begin
                dg[mcur] = (dg[mcur] + 1) % lim[mcur];
                tag = "R9";
            end
            if (sl) begin
                mcur = (mcur + 1) % 8;
                if (!inc) tag = "R8";
            end
        end else if (t) begin
            y = yr(); m = mo(); d = dy();
            if (d < mlen(y, m)) begin
                d++; tag = "R2";
            end else begin
                d = 1;
                tag = (m == 2) ? "R4" : "R3";
                if (m < 12) m++;
                else begin
                    m = 1; y = (y == 9999) ? 1 : y + 1; tag = "R5";
                end
            end
            put(y, m, d);
        end else begin
            tag = "R10";
        end
        sb.push_back('{exp: pack(), tag: tag});
    endtask

    task automatic idle();
        @(negedge clk);
        day_tick = 0; key_mode = 0; key_sel = 0; key_inc = 0;
    endtask

    // Edit the date through the keys, then leave setting mode.
    task automatic set_date(int y, int m, int d);
        int td[8];
        td[0] = y / 1000; td[1] = (y / 100) % 10; td[2] = (y / 10) % 10; td[3] = y % 10;
        td[4] = m / 10;   td[5] = m % 10;
        td[6] = d / 10;   td[7] = d % 10;
        if (!mset) step(0, 1, 0, 0);
        for (int p = 0; p < 8; p++) begin
            int n;
            n = (td[p] - dg[p] + lim[p]) % lim[p];
            repeat (n) step(0, 0, 0, 1);
            step(0, 0, 1, 0);
        end
        step(0, 1, 0, 0);
    endtask

    // Monitor: compares one queued item per cycle after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, actual(), it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; day_tick = 0; key_mode = 0; key_sel = 0; key_inc = 0;
        mset = 0; mcur = 0;
        put(1, 1, 1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1", actual(), pack());

        // Four-plus years of ticks from reset (R2, R3, R4, R5).
        repeat (1500) step(1, 0, 0, 0);

        // Keys outside setting mode (R10).
        step(0, 0, 1, 0);
        step(0, 0, 0, 1);
        step(0, 0, 1, 1);

        // Century and four-hundred-year rules (R4).
        set_date(1900, 2, 28); repeat (2) step(1, 0, 0, 0);
        set_date(2000, 2, 28); repeat (3) step(1, 0, 0, 0);
        set_date(2100, 2, 27); repeat (3) step(1, 0, 0, 0);
        set_date(2024, 2, 20); repeat (12) step(1, 0, 0, 0);
        set_date(1999, 9, 29); repeat (70) step(1, 0, 0, 0);

        // Year wrap and BCD carry (R5).
        set_date(9999, 12, 30); repeat (3) step(1, 0, 0, 0);
        set_date(199, 12, 31);  step(1, 0, 0, 0);
        set_date(0, 12, 31);    step(1, 0, 0, 0);

        // Exit repair (R11).
        set_date(2023, 0, 0);
        set_date(2024, 19, 39);
        set_date(2024, 2, 39);
        set_date(2023, 4, 31);
        set_date(2023, 11, 0);
        step(1, 0, 0, 0);

        // Frozen counting, cursor wrap, digit wrap (R7, R8, R9).
        step(0, 1, 0, 0);
        repeat (4) step(1, 0, 0, 0);
        repeat (9) step(0, 0, 1, 0);
        repeat (3) step(0, 0, 1, 0);
        repeat (3) step(0, 0, 0, 1);
        step(0, 0, 1, 0);
        repeat (11) step(0, 0, 0, 1);
        step(0, 0, 1, 0);
        repeat (5) step(0, 0, 0, 1);
        step(0, 0, 1, 1);
        step(1, 0, 1, 1);
        step(0, 1, 0, 0);

        // Mode key precedence (R12).
        step(1, 1, 1, 1);
        step(1, 1, 1, 1);
        repeat (5) step(1, 0, 0, 0);

        idle();
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule